// File: doc/BRIEF.md
# Sprite attribute pointer controller

This block owns the 8-bit pointer into primary sprite attribute memory and the path that writes processor data into that memory. Outside rendering, a data write stores its byte at the pointer and advances the pointer by one. While the picture is being rendered, a data write leaves memory untouched and instead moves the pointer by four with its two low bits cleared. Throughout the sprite-fetch part of each rendered line, the pointer is held at zero.

The block also carries the 6-bit sprite index used by sprite evaluation. After the evaluation copy has finished, each evaluation step advances that index modulo 64. The secondary-memory access of that step becomes a read, whose index is the secondary address with its top bit dropped.

Top module: `attr_ptr_ctrl`

## Requirements
- R1: After reset the pointer (`ram_addr`) and the sprite index (`spr_idx`) are 0, and `ram_we` and `sec_rd` are low.
- R2: A data write outside rendering drives `ram_we` high in the same cycle, with `ram_addr` equal to the current pointer and `ram_wdata` equal to `wr_data`. From the next cycle the pointer is its old value plus 1, wrapping from 255 to 0.
- R3: A data write during rendering keeps `ram_we` low, so attribute memory is not modified.
- R4: A data write during rendering, outside the fetch window, sets the pointer to ((pointer + 4) mod 256) AND 0xFC.
- R5: "During rendering" means `bg_en` or `spr_en` is high and `line` is below 240 or equal to PRE_LINE (261). Lines 240 to 260 never count as rendering.
- R6: During rendering, on dots 257 to 320 inclusive, the pointer is 0 from the next cycle. This holds even when a pointer load or a data write is presented in the same cycle.
- R7: Outside the fetch window, a pointer load (`addr_wr`) sets the pointer to `wr_data` from the next cycle. A load takes priority over a data write in the same cycle.
- R8: `eval_start` loads the sprite index with pointer bits [7:2].
- R9: An evaluation step with `copy_done` high, and no `eval_start`, advances the sprite index by 1 modulo 64. In the same cycle it drives `sec_rd` high with `sec_idx` = `sec_addr` AND 0x1F, including when `sec_addr` is 0x20 or above.
- R10: An evaluation step with `copy_done` low leaves the sprite index unchanged and keeps `sec_rd` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Processor write to the pointer |
| data_wr | input | 1 | Processor write to attribute data |
| wr_data | input | 8 | Processor write byte |
| line | input | 9 | Current scanline, pre-render line = 261 |
| dot | input | 9 | Current cycle within the line |
| bg_en | input | 1 | Background rendering enable |
| spr_en | input | 1 | Sprite rendering enable |
| eval_start | input | 1 | Start of sprite evaluation, loads sprite index |
| eval_step | input | 1 | One sprite evaluation step |
| copy_done | input | 1 | Evaluation copy has finished |
| sec_addr | input | 6 | Secondary memory address from evaluation |
| ram_addr | output | 8 | Attribute memory address (the pointer) |
| ram_we | output | 1 | Attribute memory write enable |
| ram_wdata | output | 8 | Attribute memory write data |
| spr_idx | output | 6 | Sprite index used during evaluation |
| sec_rd | output | 1 | Secondary memory read strobe |
| sec_idx | output | 5 | Secondary memory read index |

## Verification
`ram_we`, `ram_wdata`, `sec_rd` and `sec_idx` are combinational and are due in the same cycle as their stimulus. Changes to the pointer and the sprite index are due one clock after it. The bench drives every input just after a falling edge and checks the same-cycle outputs 1 ns later, against a model still holding the old state. It then advances the model to the next state, so the registered results are compared in the following cycle, before the next clock edge.

// File: rtl/attr_ptr_ctrl.sv
module attr_ptr_ctrl #(
  parameter int AW       = 8,
  parameter int LW       = 9,
  parameter int VIS      = 240,
  parameter int PRE_LINE = 261,
  parameter int FETCH_LO = 257,
  parameter int FETCH_HI = 320,
  parameter int IW       = 6,
  parameter int SW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic          data_wr,
  input  logic [AW-1:0] wr_data,
  input  logic [LW-1:0] line,
  input  logic [LW-1:0] dot,
  input  logic          bg_en,
  input  logic          spr_en,
  input  logic          eval_start,
  input  logic          eval_step,
  input  logic          copy_done,
  input  logic [SW:0]   sec_addr,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic [AW-1:0] ram_wdata,
  output logic [IW-1:0] spr_idx,
  output logic          sec_rd,
  output logic [SW-1:0] sec_idx
);
  localparam logic [AW-1:0] STEP4 = AW'(4);
  localparam logic [AW-1:0] LOMSK = ~AW'(3);

  logic [AW-1:0] ptr;
  logic [IW-1:0] idx;
  logic          drawing, fetch, adv;

  assign drawing = (bg_en | spr_en) &&
                   ((line < LW'(VIS)) || (line == LW'(PRE_LINE)));
  assign fetch   = drawing && (dot >= LW'(FETCH_LO)) && (dot <= LW'(FETCH_HI));
  assign adv     = eval_step && copy_done;

  assign ram_addr  = ptr;
  assign ram_wdata = wr_data;
  assign ram_we    = data_wr && !addr_wr && !drawing;
  assign spr_idx   = idx;
  assign sec_rd    = adv;
  assign sec_idx   = sec_addr[SW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr <= '0;
    else if (fetch)      ptr <= '0;
    else if (addr_wr)    ptr <= wr_data;
    else if (data_wr)    ptr <= drawing ? ((ptr + STEP4) & LOMSK) : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          idx <= '0;
    else if (eval_start) idx <= ptr[AW-1:2];
    else if (adv)        idx <= idx + 1'b1;
  end

  p_norm_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && !drawing) |=> ptr == $past(ptr) + 1'b1);
  p_no_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && drawing) |-> !ram_we);
  p_glitch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !addr_wr && drawing && !fetch) |=> (ptr[1:0] == 2'b00 &&
      ptr[AW-1:2] == $past(ptr[AW-1:2]) + 1'b1));
  p_fetch_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |=> ptr == '0);
  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !fetch) |=> ptr == $past(wr_data));
  p_idx_adv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !eval_start) |=> idx == $past(idx) + 1'b1);
  p_idx_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_step && !eval_start) |=> $stable(idx));
endmodule

// File: tb/attr_ptr_ctrl_tb_top.sv
module attr_ptr_ctrl_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       addr_wr = 0, data_wr = 0, bg_en = 0, spr_en = 0;
  logic       eval_start = 0, eval_step = 0, copy_done = 0;
  logic [7:0] wr_data = 0;
  logic [8:0] line = 0, dot = 0;
  logic [5:0] sec_addr = 0;
  logic [7:0] ram_addr, ram_wdata;
  logic       ram_we, sec_rd;
  logic [5:0] spr_idx;
  logic [4:0] sec_idx;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_ptr = 0;
  logic [5:0] m_idx = 0;

  attr_ptr_ctrl dut_i (.*);

  always #5 clk = ~clk;

  function automatic bit f_draw(input logic b, input logic s, input logic [8:0] l);
    return (b | s) && (l < 9'd240 || l == 9'd261);
  endfunction
  function automatic logic [7:0] f_next_ptr(input logic [7:0] p);
    bit dr = f_draw(bg_en, spr_en, line);
    if (dr && dot >= 9'd257 && dot <= 9'd320) return 8'd0;
    if (addr_wr) return wr_data;
    if (data_wr) return dr ? ((p + 8'd4) & 8'hFC) : p + 8'd1;
    return p;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step_check();
    bit dr;
    #1;
    dr = f_draw(bg_en, spr_en, line);
    chk("R2 R7 pointer", ram_addr, m_ptr);
    chk("R9 R10 index", spr_idx, m_idx);
    if (data_wr && !addr_wr && !dr) begin
      chk("R2 we", ram_we, 1); chk("R2 wdata", ram_wdata, wr_data);
    end else chk("R3 R5 we", ram_we, 0);
    chk("R9 R10 sec_rd", sec_rd, eval_step && copy_done);
    if (eval_step && copy_done) chk("R9 sec_idx", sec_idx, sec_addr & 6'h1F);
    if (eval_start) m_idx = m_ptr[7:2];
    else if (eval_step && copy_done) m_idx = m_idx + 6'd1;
    m_ptr = f_next_ptr(m_ptr);
    @(negedge clk);
  endtask

  task automatic idle();
    addr_wr = 0; data_wr = 0; eval_start = 0; eval_step = 0; copy_done = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    #1;
    chk("R1 ptr", ram_addr, 0); chk("R1 idx", spr_idx, 0);
    chk("R1 we", ram_we, 0); chk("R1 sec_rd", sec_rd, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 wrap 255 -> 0
    addr_wr = 1; wr_data = 8'hFF; step_check(); idle();
    data_wr = 1; wr_data = 8'h5A; line = 9'd250; bg_en = 1; step_check(); idle();
    chk("R2 wrap", ram_addr, 0);
    // R4 glitch bump 0xFE -> 0x00, 0x03 -> 0x04
    addr_wr = 1; wr_data = 8'hFE; step_check(); idle();
    data_wr = 1; line = 9'd10; dot = 9'd5; step_check(); idle();
    chk("R4 FE", ram_addr, 0);
    addr_wr = 1; wr_data = 8'h03; line = 9'd250; step_check(); idle();
    data_wr = 1; line = 9'd261; spr_en = 1; bg_en = 0; step_check(); idle();
    chk("R4 03", ram_addr, 8'h04);
    // R5 line 240 not rendering
    data_wr = 1; line = 9'd240; step_check(); idle();
    chk("R5 line 240", ram_addr, 8'h05);
    // R6 fetch beats load
    addr_wr = 1; wr_data = 8'h77; line = 9'd0; dot = 9'd320; step_check(); idle();
    chk("R6 fetch clear", ram_addr, 0);
    // R8 / R9 index with sec_addr >= 0x20
    addr_wr = 1; wr_data = 8'hFC; dot = 9'd0; line = 9'd250; step_check(); idle();
    eval_start = 1; step_check(); idle();
    chk("R8 load", spr_idx, 6'h3F);
    eval_step = 1; copy_done = 1; sec_addr = 6'h25; step_check(); idle();
    chk("R9 wrap", spr_idx, 0);
    eval_step = 1; step_check(); idle();
    chk("R10 hold", spr_idx, 0);
    // random phase
    for (int i = 0; i < 20000; i++) begin
      addr_wr    = ($urandom % 8) == 0;
      data_wr    = ($urandom % 3) == 0;
      wr_data    = 8'($urandom);
      bg_en      = ($urandom % 3) != 0;
      spr_en     = ($urandom % 3) == 0;
      line       = (($urandom % 4) == 0) ? 9'd261 : 9'($urandom % 262);
      dot        = 9'($urandom % 341);
      eval_start = ($urandom % 40) == 0;
      eval_step  = ($urandom % 2) == 0;
      copy_done  = ($urandom % 2) == 0;
      sec_addr   = 6'($urandom);
      step_check();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule